// File: doc/BRIEF.md
# Radix-4 Unsigned Row-Serial Multiplier

This block multiplies two unsigned operands by treating the multiplier as a string of base-4 digits. Each digit comes from a pair of multiplier bits that does not overlap any other pair. Pairing starts at the least significant bit. Each digit picks one partial-product row: zero, the multiplicand, the multiplicand doubled, or the multiplicand tripled. The tripled row is formed as the doubled row plus the plain one. An 8-bit multiplier therefore gives four rows instead of eight. The multiplier needs no padding bits and no signed recoding.

The rows are summed one per clock. A one-cycle `start` pulse captures both operands and clears the accumulator. On each following cycle, the row for the next digit is shifted left by twice its digit index and added to the accumulator. After the last digit, `done` rises. `done` and the product then stay unchanged until the next `start`. A `start` that arrives during a multiplication abandons it and begins again with the new operands.

Top module: `r4_seq_mul`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset is released, `product` is 0 and both `busy` and `done` are 0.
- R2: Digit i is multiplier bits [2i+1:2i], with digit 0 at the least significant bits. Its row enters the sum shifted left by 2i bits. An 8-bit multiplier gives exactly four digits.
- R3: A digit of value 0 (bits 00) adds nothing. A digit of value 1 (bits 01) adds the multiplicand unchanged.
- R4: A digit of value 2 (bits 10) adds the multiplicand shifted left by one bit.
- R5: A digit of value 3 (bits 11) adds three times the multiplicand, formed as the value-1 row plus the value-2 row.
- R6: Let `start` be sampled high at clock edge k. `done` is then 1 after edge k+BW/2, and `product` equals the full unsigned product of the captured operands. `done` is 0 before that edge.
- R7: `busy` is 1 from the edge after `start` until the final row has been added. `busy` and `done` are never 1 together.
- R8: After `done`, `product` and `done` hold until the next `start`. Changes on `mcand` or `mplier` when no `start` is present leave the result unchanged.
- R9: A `start` during a multiplication restarts it with the operands present at that edge. The earlier operation leaves no trace in the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request that captures operands and begins a multiplication |
| mcand | input | AW (8) | Unsigned multiplicand |
| mplier | input | BW (8) | Unsigned multiplier, BW even |
| product | output | AW+BW (16) | Accumulated product, final once `done` is high |
| busy | output | 1 | Rows are still being added |
| done | output | 1 | Product is complete and held |

## Verification
The bench builds two copies of the block that run side by side. One uses the default 8x8 size. The other uses 6x6, where all 4096 operand pairs fit within the cycle budget, so that copy is checked exhaustively, including operands whose digits are all 3. The 8x8 copy covers every multiplicand against multipliers built from repeated nibbles, which include all-ones and all-digit-3 patterns. It also gets directed cases that isolate each digit value and each digit position, and checks of exact latency, hold and restart.

// File: rtl/r4_mul_pkg.sv
// Package: shared digit encoding for the radix-4 unsigned multiplier.
// Assumes: digits are unsigned 2-bit values taken from non-overlapping bit pairs.
package r4_mul_pkg;

    typedef enum logic [1:0] {
        DIG_ZERO  = 2'b00,
        DIG_ONE   = 2'b01,
        DIG_TWO   = 2'b10,
        DIG_THREE = 2'b11
    } r4_digit_e;

endpackage

// File: rtl/r4_row_gen.sv
// Module: r4_row_gen
// Does: turns one base-4 digit and the multiplicand into a partial-product row.
//       The row is 0, 1x, 2x or 3x the multiplicand.
// Assumes: the 3x value fits in AW+2 bits, which is always true.
module r4_row_gen #(
    parameter int AW = 8,
    localparam int RW = AW + 2
) (
    input  logic [AW-1:0] mcand,
    input  logic [1:0]    digit,
    output logic [RW-1:0] row
);
    import r4_mul_pkg::*;

    logic [RW-1:0] x1;
    logic [RW-1:0] x2;

    assign x1 = RW'(mcand);
    assign x2 = x1 << 1;

    // Pick the row for this digit; 3x is built as 1x plus 2x.
    always_comb begin
        unique case (r4_digit_e'(digit))
            DIG_ZERO:  row = '0;
            DIG_ONE:   row = x1;
            DIG_TWO:   row = x2;
            DIG_THREE: row = x1 + x2;
            default:   row = '0;
        endcase
    end
endmodule

// File: rtl/r4_step_ctrl.sv
// Module: r4_step_ctrl
// Does: steps a digit index from 0 to NG-1, one step per cycle after start.
//       It raises busy while stepping and done after the last step.
// Assumes: start is a single-cycle pulse. A start while busy restarts the count.
module r4_step_ctrl #(
    parameter int NG = 4,
    localparam int IW = (NG > 1) ? $clog2(NG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] LAST = IW'(NG - 1);

    // Sequence the digit index and the busy/done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            idx  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            done <= 1'b0;
            idx  <= '0;
        end else if (busy) begin
            if (idx == LAST) begin
                busy <= 1'b0;
                done <= 1'b1;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/r4_accum.sv
// Module: r4_accum
// Does: captures the operands on start. On each busy cycle it adds the row
//       for the current digit, shifted left by twice the digit index.
// Assumes: BW is even and at least 4, so a row always fits in the product width.
module r4_accum #(
    parameter int AW = 8,
    parameter int BW = 8,
    localparam int NG = BW / 2,
    localparam int IW = (NG > 1) ? $clog2(NG) : 1,
    localparam int PW = AW + BW,
    localparam int RW = AW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          busy,
    input  logic [IW-1:0] idx,
    input  logic [AW-1:0] mcand,
    input  logic [BW-1:0] mplier,
    output logic [PW-1:0] product
);
    logic [AW-1:0] a_q;
    logic [BW-1:0] b_q;
    logic [1:0]    digit;
    logic [RW-1:0] row;
    logic [PW-1:0] row_sh;

    // Select the current 2-bit digit from the captured multiplier.
    always_comb begin
        digit = 2'b00;
        for (int g = 0; g < NG; g++) begin
            if (idx == IW'(g)) digit = b_q[2*g +: 2];
        end
    end

    r4_row_gen #(.AW(AW)) u_row (
        .mcand (a_q),
        .digit (digit),
        .row   (row)
    );

    // Align the row to its digit weight.
    assign row_sh = PW'(row) << {idx, 1'b0};

    // Capture operands on start and accumulate one row per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            product <= '0;
        end else if (start) begin
            a_q     <= mcand;
            b_q     <= mplier;
            product <= '0;
        end else if (busy) begin
            product <= product + row_sh;
        end
    end
endmodule

// File: rtl/r4_seq_mul.sv
// Module: r4_seq_mul (top)
// Does: unsigned AW x BW multiply. The multiplier is split into BW/2 radix-4
//       digits, and one partial-product row is added per clock.
// Assumes: BW is even and at least 4. Reset is synchronous and active low.
module r4_seq_mul #(
    parameter int AW = 8,
    parameter int BW = 8,
    localparam int NG = BW / 2,
    localparam int IW = (NG > 1) ? $clog2(NG) : 1,
    localparam int PW = AW + BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] mcand,
    input  logic [BW-1:0] mplier,
    output logic [PW-1:0] product,
    output logic          busy,
    output logic          done
);
    logic [IW-1:0] idx;

    r4_step_ctrl #(.NG(NG)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done),
        .idx   (idx)
    );

    r4_accum #(.AW(AW), .BW(BW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .idx     (idx),
        .mcand   (mcand),
        .mplier  (mplier),
        .product (product)
    );
endmodule

// File: rtl/r4_seq_mul_chk.sv
// Module: r4_seq_mul_chk
// Does: checks handshake timing, latency, hold and final value at the ports
//       of r4_seq_mul. It is attached to the top by the bind below.
module r4_seq_mul_chk #(
    parameter int AW = 8,
    parameter int BW = 8,
    localparam int NG = BW / 2,
    localparam int PW = AW + BW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] mcand,
    input logic [BW-1:0] mplier,
    input logic [PW-1:0] product,
    input logic          busy,
    input logic          done
);
    logic [AW-1:0] m_a;
    logic [BW-1:0] m_b;
    logic [15:0]   steps;

    // Keep its own copy of the operands and count the busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_a   <= '0;
            m_b   <= '0;
            steps <= '0;
        end else if (start) begin
            m_a   <= mcand;
            m_b   <= mplier;
            steps <= '0;
        end else if (busy) begin
            steps <= steps + 16'd1;
        end
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy && !done); // R7
    AST_BUSY_EXCL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R7
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> steps == 16'(NG)); // R6
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(product)); // R8
    AST_PRODUCT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> product == PW'(m_a) * PW'(m_b)); // R6
endmodule

bind r4_seq_mul r4_seq_mul_chk #(.AW(AW), .BW(BW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .product (product),
    .busy    (busy),
    .done    (done)
);

// File: tb/tb_r4_seq_mul.sv
module tb_r4_seq_mul;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [5:0]  a6 = '0, b6 = '0;
    logic [15:0] p8;
    logic [11:0] p6;
    logic busy8, done8, busy6, done6;
    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk; // 50 MHz

    r4_seq_mul #(.AW(8), .BW(8)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(a8), .mplier(b8),
        .product(p8), .busy(busy8), .done(done8));

    r4_seq_mul #(.AW(6), .BW(6)) dut_s6 (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(a6), .mplier(b6),
        .product(p6), .busy(busy6), .done(done6));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Start both copies, then sample exactly four edges later.
    task automatic run_op(input logic [7:0] xa, input logic [7:0] xb,
                          input logic [5:0] ya, input logic [5:0] yb, input string req);
        @(negedge clk);
        a8 = xa; b8 = xb; a6 = ya; b6 = yb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk({req, " done8 low one edge early (R6)"}, 32'(done8), 32'd0);
        @(negedge clk);
        chk({req, " done8 (R6)"}, 32'(done8), 32'd1);
        chk({req, " product8"}, 32'(p8), 32'(xa) * 32'(xb));
        chk({req, " product6 (R6)"}, 32'(p6), 32'(ya) * 32'(yb));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 product in reset", 32'(p8), 32'd0);
        chk("R1 busy in reset", 32'(busy8), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", 32'(done8), 32'd0);
        chk("R1 busy after reset", 32'(busy8), 32'd0);
        chk("R1 product after reset", 32'(p8), 32'd0);

        // R3: digit 0 and digit 1
        run_op(8'hB7, 8'h00, 6'h2D, 6'h00, "R3 all digit 0");
        run_op(8'hB7, 8'h01, 6'h2D, 6'h01, "R3 digit 1 low");
        // R4: digit 2
        run_op(8'hC9, 8'h02, 6'h33, 6'h02, "R4 digit 2 low");
        // R5: digit 3 and all-3 / all-ones
        run_op(8'hE5, 8'h03, 6'h3F, 6'h03, "R5 digit 3 low");
        run_op(8'hFF, 8'hFF, 6'h3F, 6'h3F, "R5 all ones");
        // R2: digit positions isolated
        run_op(8'h9D, 8'h04, 6'h15, 6'h04, "R2 digit 1 position");
        run_op(8'h9D, 8'h20, 6'h15, 6'h20, "R2 digit 2 position");
        run_op(8'h9D, 8'h40, 6'h15, 6'h10, "R2 digit 3 position");
        run_op(8'h9D, 8'hE4, 6'h15, 6'h39, "R2 mixed digits 3,2,1,0");

        // R7: busy during the operation
        @(negedge clk);
        a8 = 8'h5A; b8 = 8'hC3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7 busy after start", 32'(busy8), 32'd1);
        chk("R7 done low while busy", 32'(done8), 32'd0);
        repeat (3) @(negedge clk);
        @(negedge clk);
        chk("R7 busy low at done", 32'(busy8), 32'd0);

        // R8: hold and ignore operand changes without start
        a8 = 8'h11; b8 = 8'h22;
        repeat (3) @(negedge clk);
        chk("R8 product held", 32'(p8), 32'h5A * 32'hC3);
        chk("R8 done held", 32'(done8), 32'd1);

        // R9: restart while busy
        @(negedge clk);
        a8 = 8'h7E; b8 = 8'hFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        a8 = 8'hA3; b8 = 8'h6C; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 no early done after restart", 32'(done8), 32'd0);
        @(negedge clk);
        chk("R9 restart product", 32'(p8), 32'hA3 * 32'h6C);

        // R6: exhaustive 6x6, and an 8x8 sweep over repeated-nibble multipliers
        for (int n = 0; n < 4096; n++) begin
            run_op(8'(n[7:0] ^ n[11:4]), {n[11:8], n[11:8]}, n[5:0], n[11:6], "R6 sweep");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule